// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between a host data register and the serializer of an audio transmitter. Each 32-bit word that the host writes is unpacked into one or two audio samples. Runtime mode inputs choose how this is done: the container size in bytes, the number of valid bits, the byte order inside the container, which end of the container holds the valid bits, and how samples are assigned to the two channels. Every sample leaves the block as a 24-bit word with its most significant bit at bit 23. Each sample carries a channel tag and is placed in a small transmit FIFO. The serializer drains the FIFO through a valid/ready port.

The FIFO level drives steady status outputs: space free, empty, full, and room for one chunk. A write that does not fit, and a serializer request that finds nothing to send while transmission is on, each raise a one-cycle event. Channel tag 0 means the first channel and tag 1 means the second.

Top module: `audio_word_formatter`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty. `out_valid` is 0, `ev_empty` and `ev_ready` are 1, `ev_full`, `ev_overrun` and `ev_underrun` are 0, and the toggle channel pointer points at channel tag 0.
- R2: The sample container is the lowest N bytes of the written word, where N = `cfg_bytes_m1` + 1. When `cfg_big_endian` is 0, byte 0 (bits 7:0) is least significant. When it is 1, byte 0 is most significant.
- R3: When `cfg_msb_just` is 0, the valid bits are the lowest V bits of the container. When it is 1, they are the highest V bits. V is `cfg_vbits`, except that 0 or any value above N*8 means N*8. Container bits outside the valid bits are ignored.
- R4: The output sample holds the valid bits with their MSB at bit 23. Samples with more than 24 valid bits keep their top 24. Shorter samples are padded with zeros at the LSB end.
- R5: Indexed access (`cfg_access` = 0, or the reserved value 3) with `cfg_dual` = 1 tags each sample with `wr_chan`.
- R6: Toggle access (`cfg_access` = 1) with `cfg_dual` = 1 tags accepted writes 0, 1, 0, ... in turn. A write that is dropped does not advance the pointer.
- R7: Interleaved access (`cfg_access` = 2) with `cfg_dual` = 1 pushes two entries in one cycle. The sample from bits 15:0 goes first with tag 0, then the sample from bits 31:16 with tag 1. The container size is capped at 2 bytes.
- R8: With `cfg_dual` = 0 every sample is tagged 0. Interleaved access then pushes only the low half-word sample, and toggle access does not advance the pointer.
- R9: The FIFO holds DEPTH (default 8) entries in write order. `out_valid` is high while it is non-empty, an entry leaves when `out_valid` and `out_ready` are both high, and an entry that is presented but not taken stays unchanged.
- R10: `ev_ready` is high while at least one entry is free, `ev_full` while all entries are used, and `ev_empty` while none are used.
- R11: `ev_chunk` is high while the number of free entries is at least `cfg_chunk`, with 0 treated as 1.
- R12: A write needing more entries than are free is dropped whole, judged on the count before any pop in the same cycle. `ev_overrun` is then high for the following cycle, and the FIFO contents are unchanged.
- R13: When `tx_en`, `out_ready` and an empty FIFO coincide in a cycle, `ev_underrun` is high in the next cycle. It is never raised while `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bytes_m1 | input | 2 | Container bytes minus one |
| cfg_vbits | input | 6 | Valid bits per sample |
| cfg_big_endian | input | 1 | 1: byte 0 is most significant |
| cfg_msb_just | input | 1 | 1: valid bits at container MSB end |
| cfg_access | input | 2 | 0 indexed, 1 toggle, 2 interleaved, 3 as indexed |
| cfg_dual | input | 1 | 1: two channels, 0: single channel |
| cfg_chunk | input | 4 | Chunk size in entries |
| tx_en | input | 1 | Transmission running |
| wr_en | input | 1 | Host data word write strobe |
| wr_chan | input | 1 | Channel tag for indexed access |
| wr_data | input | 32 | Host data word |
| out_valid | output | 1 | FIFO head is valid |
| out_ready | input | 1 | Serializer takes the head |
| out_sample | output | 24 | MSB-aligned sample at the head |
| out_chan | output | 1 | Channel tag at the head |
| ev_ready | output | 1 | At least one entry free |
| ev_empty | output | 1 | FIFO empty |
| ev_full | output | 1 | FIFO full |
| ev_chunk | output | 1 | Room for one chunk |
| ev_overrun | output | 1 | Previous cycle dropped a write |
| ev_underrun | output | 1 | Previous cycle had a request with nothing to send |

## Verification
The assertions check on every cycle that the FIFO count stays within its depth and that a head entry not taken is held unchanged. They also check that a dropped write leaves the count as it was and that a request against an empty FIFO is followed by an underrun event. The bench scenarios are what show the sample values. These are the byte reordering, the two justifications, truncation and padding, clamping of the valid-bit count, and the channel tags of the three access modes and of single-channel operation. A scoreboard checks each of these against hand-derived samples. The scenarios also fill the FIFO to show the chunk threshold and that drops do not reorder or lose the entries already accepted.

// File: rtl/afmt_pkg.sv
// Shared types and codes for the audio word formatter.
// Assumes a 32-bit host word and a 24-bit output sample.
package afmt_pkg;
    localparam int WORD_W   = 32;
    localparam int SAMPLE_W = 24;

    typedef enum logic [1:0] {
        ACC_INDEXED = 2'd0,
        ACC_TOGGLE  = 2'd1,
        ACC_INTLV   = 2'd2,
        ACC_RSVD    = 2'd3
    } access_e;

    typedef struct packed {
        logic                chan;
        logic [SAMPLE_W-1:0] sample;
    } item_t;
endpackage

// File: rtl/afmt_unpack.sv
// Extracts one sample from a host word: it picks the container bytes, reorders
// them, selects the valid bits and left-aligns the result to SAMPLE_W bits.
// Assumes WORD_W is a multiple of 8 and at least SAMPLE_W. Purely combinational.
module afmt_unpack #(
    parameter int WORD_W   = 32,
    parameter int SAMPLE_W = 24
) (
    input  logic [WORD_W-1:0]   word,
    input  logic [1:0]          bytes_m1,
    input  logic                cap_two,
    input  logic [5:0]          vbits,
    input  logic                big_endian,
    input  logic                msb_just,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int NBYTES = WORD_W / 8;
    localparam logic [WORD_W-1:0] ONES = '1;

    logic [WORD_W-1:0] cont;
    logic [WORD_W-1:0] aligned;
    int                nbytes;
    int                cbits;
    int                vbe;

    // Build the container, clamp the valid width and left-align the valid bits.
    always_comb begin
        nbytes = int'(bytes_m1) + 1;
        if (cap_two && nbytes > 2) nbytes = 2;
        cbits = nbytes * 8;
        cont  = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nbytes) begin
                if (big_endian) cont[8*(nbytes-1-i) +: 8] = word[8*i +: 8];
                else            cont[8*i +: 8]            = word[8*i +: 8];
            end
        end
        vbe = int'(vbits);
        if (vbe == 0 || vbe > cbits) vbe = cbits;
        if (msb_just) aligned = (cont << (WORD_W - cbits)) & ~(ONES >> vbe);
        else          aligned = cont << (WORD_W - vbe);
        sample = aligned[WORD_W-1 -: SAMPLE_W];
    end
endmodule

// File: rtl/afmt_chan_seq.sv
// Decides how many FIFO entries a write makes and which channel tag each one
// gets. It also holds the toggle pointer, which advances only on accepted writes.
// Assumes accept comes from the FIFO space check for this cycle's push count.
module afmt_chan_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] access,
    input  logic       dual,
    input  logic       wr_en,
    input  logic       wr_chan,
    input  logic       accept,
    output logic [1:0] push_n,
    output logic       chan0,
    output logic       chan1,
    output logic       cap_two
);
    import afmt_pkg::*;

    logic tog;

    // Choose push count and tags from access mode and channel mode.
    always_comb begin
        chan1   = 1'b1;
        cap_two = 1'b0;
        unique case (access_e'(access))
            ACC_TOGGLE: begin
                push_n = 2'd1;
                chan0  = dual & tog;
            end
            ACC_INTLV: begin
                push_n  = dual ? 2'd2 : 2'd1;
                chan0   = 1'b0;
                cap_two = 1'b1;
            end
            default: begin
                push_n = 2'd1;
                chan0  = dual & wr_chan;
            end
        endcase
        if (!wr_en) push_n = 2'd0;
    end

    // Toggle pointer advances on each accepted two-channel toggle write.
    always_ff @(posedge clk) begin
        if (!rst_n) tog <= 1'b0;
        else if (wr_en && accept && dual && access == ACC_TOGGLE) tog <= ~tog;
    end

    // R6: an accepted toggle write in two-channel mode flips the next tag.
    p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && accept && dual && access == ACC_TOGGLE) |=> (chan0 != $past(chan0) || access != ACC_TOGGLE || !dual));
endmodule

// File: rtl/afmt_fifo.sv
// Transmit FIFO that can take zero, one or two entries per cycle and give one.
// Assumes DEPTH is a power of two and at least 2. A push that does not fit in
// the space counted before this cycle's pop is refused whole.
module afmt_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 25
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                push_n,
    input  logic [DW-1:0]             din0,
    input  logic [DW-1:0]             din1,
    output logic                      fits,
    output logic                      pop_valid,
    input  logic                      pop_ready,
    output logic [DW-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop;
    logic [CW-1:0] add_n;

    // Space check and handshake decode.
    always_comb begin
        fits      = (int'(count) + int'(push_n)) <= DEPTH;
        pop_valid = (count != '0);
        pop       = pop_valid && pop_ready;
        add_n     = fits ? CW'(push_n) : '0;
        dout      = mem[rd_ptr];
    end

    // Storage writes, one or two consecutive slots.
    always_ff @(posedge clk) begin
        if (fits && push_n != 2'd0) mem[wr_ptr] <= din0;
        if (fits && push_n == 2'd2) mem[wr_ptr + AW'(1)] <= din1;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(add_n);
            if (pop) rd_ptr <= rd_ptr + AW'(1);
            count <= count + add_n - CW'(pop);
        end
    end

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_hold_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready) |=> (pop_valid && $stable(dout)));
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0 && !fits && !pop_ready) |=> $stable(count));
endmodule

// File: rtl/audio_word_formatter.sv
// Top of the audio word formatter. Host words are unpacked in one or two lanes,
// tagged by the channel sequencer and stored in the transmit FIFO. FIFO levels
// become status outputs, and drops and empty requests become one-cycle events.
// Assumes the configuration inputs are held steady while writes are in flight.
module audio_word_formatter #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_bytes_m1,
    input  logic [5:0]  cfg_vbits,
    input  logic        cfg_big_endian,
    input  logic        cfg_msb_just,
    input  logic [1:0]  cfg_access,
    input  logic        cfg_dual,
    input  logic [3:0]  cfg_chunk,
    input  logic        tx_en,
    input  logic        wr_en,
    input  logic        wr_chan,
    input  logic [31:0] wr_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [23:0] out_sample,
    output logic        out_chan,
    output logic        ev_ready,
    output logic        ev_empty,
    output logic        ev_full,
    output logic        ev_chunk,
    output logic        ev_overrun,
    output logic        ev_underrun
);
    import afmt_pkg::*;

    localparam int CW    = $clog2(DEPTH+1);
    localparam int LANES = 2;
    localparam int DW    = $bits(item_t);

    logic [1:0]          push_n;
    logic                chan0, chan1, cap_two, fits;
    logic [SAMPLE_W-1:0] lane_smp [LANES];
    logic [CW-1:0]       count;
    logic [DW-1:0]       head;
    item_t               item0, item1, head_item;
    int                  need;

    afmt_chan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .access(cfg_access), .dual(cfg_dual),
        .wr_en(wr_en), .wr_chan(wr_chan), .accept(fits),
        .push_n(push_n), .chan0(chan0), .chan1(chan1), .cap_two(cap_two)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        afmt_unpack #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_unpack (
            .word(wr_data >> (16*g)), .bytes_m1(cfg_bytes_m1), .cap_two(cap_two),
            .vbits(cfg_vbits), .big_endian(cfg_big_endian), .msb_just(cfg_msb_just),
            .sample(lane_smp[g])
        );
    end

    // Pack lane results into FIFO items.
    always_comb begin
        item0 = '{chan: chan0, sample: lane_smp[0]};
        item1 = '{chan: chan1, sample: lane_smp[1]};
    end

    afmt_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(push_n), .din0(item0), .din1(item1),
        .fits(fits), .pop_valid(out_valid), .pop_ready(out_ready),
        .dout(head), .count(count)
    );

    // Head fields and level status.
    always_comb begin
        head_item  = item_t'(head);
        out_sample = head_item.sample;
        out_chan   = head_item.chan;
        need       = (cfg_chunk == 4'd0) ? 1 : int'(cfg_chunk);
        ev_ready   = count < CW'(DEPTH);
        ev_full    = count == CW'(DEPTH);
        ev_empty   = count == '0;
        ev_chunk   = (DEPTH - int'(count)) >= need;
    end

    // One-cycle drop and starvation events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_overrun  <= 1'b0;
            ev_underrun <= 1'b0;
        end else begin
            ev_overrun  <= wr_en && !fits;
            ev_underrun <= tx_en && out_ready && !out_valid;
        end
    end

    p_underrun_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && out_ready && !out_valid) |=> ev_underrun);
    p_overrun_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && !$past(out_valid && out_ready)) |-> count == $past(count));
endmodule

// File: tb/audio_word_formatter_bench.sv
module audio_word_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_bytes_m1 = 2'd1;
    logic [5:0]  cfg_vbits = 6'd16;
    logic        cfg_big_endian = 1'b0;
    logic        cfg_msb_just = 1'b0;
    logic [1:0]  cfg_access = 2'd0;
    logic        cfg_dual = 1'b1;
    logic [3:0]  cfg_chunk = 4'd2;
    logic        tx_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_chan = 1'b0;
    logic [31:0] wr_data = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_chan;
    logic [23:0] out_sample;
    logic        ev_ready, ev_empty, ev_full, ev_chunk, ev_overrun, ev_underrun;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [24:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    audio_word_formatter u_audio_word_formatter (
        .clk(clk), .rst_n(rst_n), .cfg_bytes_m1(cfg_bytes_m1), .cfg_vbits(cfg_vbits),
        .cfg_big_endian(cfg_big_endian), .cfg_msb_just(cfg_msb_just),
        .cfg_access(cfg_access), .cfg_dual(cfg_dual), .cfg_chunk(cfg_chunk),
        .tx_en(tx_en), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .out_chan(out_chan), .ev_ready(ev_ready), .ev_empty(ev_empty),
        .ev_full(ev_full), .ev_chunk(ev_chunk), .ev_overrun(ev_overrun),
        .ev_underrun(ev_underrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic ch, input logic [23:0] smp, input string tag);
        exp_q.push_back({ch, smp});
        tag_q.push_back(tag);
    endtask

    task automatic write_word(input logic [31:0] w, input logic ch);
        wr_data = w;
        wr_chan = ch;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Monitor: pops scoreboard entries as the design hands out samples.
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 actual=%h expected=none", {out_chan, out_sample});
            end else begin
                check(tag_q.pop_front(), {7'd0, out_chan, out_sample}, {7'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {26'd0, out_valid, ev_empty, ev_ready, ev_full, ev_overrun, ev_underrun},
              {26'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        check("R11", {31'd0, ev_chunk}, 32'd1);

        // R5 indexed, R2 little endian, R4 padding
        expect_item(1'b1, 24'h123400, "R5");
        write_word(32'h0000_1234, 1'b1);
        cfg_big_endian = 1'b1;
        expect_item(1'b0, 24'h341200, "R2");
        write_word(32'h0000_1234, 1'b0);
        cfg_big_endian = 1'b0;
        cfg_bytes_m1 = 2'd2; cfg_vbits = 6'd24;
        expect_item(1'b0, 24'hABCDEF, "R2");
        write_word(32'h00AB_CDEF, 1'b0);
        cfg_bytes_m1 = 2'd3; cfg_vbits = 6'd32; cfg_msb_just = 1'b1;
        expect_item(1'b0, 24'h89ABCD, "R4");
        write_word(32'h89AB_CDEF, 1'b0);
        cfg_vbits = 6'd20; cfg_msb_just = 1'b0;
        expect_item(1'b1, 24'h123450, "R3");
        write_word(32'hFFF1_2345, 1'b1);
        cfg_msb_just = 1'b1;
        expect_item(1'b1, 24'h123450, "R3");
        write_word(32'h1234_5FFF, 1'b1);
        cfg_msb_just = 1'b0; cfg_bytes_m1 = 2'd0; cfg_vbits = 6'd8;
        expect_item(1'b0, 24'h5A0000, "R4");
        write_word(32'hFFFF_FF5A, 1'b0);
        cfg_bytes_m1 = 2'd1; cfg_vbits = 6'd0;
        expect_item(1'b0, 24'hBEEF00, "R3");
        write_word(32'h0000_BEEF, 1'b0);
        cfg_vbits = 6'd16;

        // R6 toggle alternation
        cfg_access = 2'd1;
        expect_item(1'b0, 24'h111100, "R6");
        write_word(32'h0000_1111, 1'b1);
        expect_item(1'b1, 24'h222200, "R6");
        write_word(32'h0000_2222, 1'b0);
        expect_item(1'b0, 24'h333300, "R6");
        write_word(32'h0000_3333, 1'b0);
        // R8 single channel
        cfg_dual = 1'b0;
        expect_item(1'b0, 24'h444400, "R8");
        write_word(32'h0000_4444, 1'b1);
        cfg_access = 2'd0;
        expect_item(1'b0, 24'h555500, "R8");
        write_word(32'h0000_5555, 1'b1);
        cfg_access = 2'd2;
        expect_item(1'b0, 24'hC3D400, "R8");
        write_word(32'hA1B2_C3D4, 1'b0);
        // R7 interleaved
        cfg_dual = 1'b1;
        expect_item(1'b0, 24'hC3D400, "R7");
        expect_item(1'b1, 24'hA1B200, "R7");
        write_word(32'hA1B2_C3D4, 1'b0);
        cfg_bytes_m1 = 2'd3; cfg_big_endian = 1'b1;
        expect_item(1'b0, 24'hD4C300, "R7");
        expect_item(1'b1, 24'hB2A100, "R7");
        write_word(32'hA1B2_C3D4, 1'b0);
        cfg_bytes_m1 = 2'd1; cfg_big_endian = 1'b0;
        repeat (6) @(negedge clk);
        check("R9", exp_q.size(), 0);

        // Fill test: R10, R11, R12
        out_ready = 1'b0;
        cfg_access = 2'd0;
        for (int i = 0; i < 7; i++) begin
            expect_item(i[0], {8'h10 + 8'(i), 8'h5A, 8'h00}, "R12");
            write_word({16'h0, 8'h10 + 8'(i), 8'h5A}, i[0]);
        end
        check("R11", {31'd0, ev_chunk}, 32'd0);
        check("R10", {29'd0, ev_ready, ev_full, ev_empty}, {29'd0, 3'b100});
        cfg_access = 2'd2;
        write_word(32'hDEAD_BEEF, 1'b0);
        check("R12", {31'd0, ev_overrun}, 32'd1);
        check("R10", {31'd0, ev_full}, 32'd0);
        cfg_access = 2'd0;
        expect_item(1'b1, 24'h775A00, "R12");
        write_word(32'h0000_775A, 1'b1);
        check("R10", {29'd0, ev_ready, ev_full, ev_overrun}, {29'd0, 3'b010});
        write_word(32'h0000_CAFE, 1'b0);
        check("R12", {31'd0, ev_overrun}, 32'd1);
        check("R9", {7'd0, out_chan, out_sample}, {7'd0, 1'b0, 24'h105A00});
        out_ready = 1'b1;
        repeat (12) @(negedge clk);
        check("R10", {31'd0, ev_empty}, 32'd1);
        check("R12", exp_q.size(), 0);
        check("R13", {31'd0, ev_underrun}, 32'd0);
        tx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R13", {31'd0, ev_underrun}, 32'd1);
        tx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R13", {31'd0, ev_underrun}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule